// File: doc/BRIEF.md
# Block floating point tag controller

This block keeps track of block floating point scaling while a radix-2 decimation-in-time FFT runs through a butterfly pipeline. Every cycle it receives the 2-bit weighting tags of the A and B words and the three most significant bits of the real and imaginary parts of A. From the tags it decides how the two operands of the complex accumulator are brought to the same weighting: either the A word is shifted right, or the product is shifted right internally. From the top bits of A it detects word growth and produces an accumulator shift code and a 2-bit output tag for each butterfly.

A 5-bit two's complement global exponent holds the weighting of the largest word in the current pass relative to the original input data. A start strobe (active low) opens an FFT. A pass strobe, high during a pass and low on its last cycle and in the gap that follows, marks the pass boundaries. When the pass strobe rises again, the exponent moves by the largest output tag seen in the pass that has just ended.

Tag encoding, used throughout: 00 means one place below the exponent, 01 equal to it, 10 one place above, 11 two places above.

Top module: `bfp_tag_ctrl`

## Requirements
- R1: While the first pass is active, both input tags are treated as 01 and their port values have no effect. The first pass runs from a cycle with start_n low up to, but not including, the cycle in which pass_n rises. A rising cycle with start_n high is not a first-pass cycle.
- R2: One cycle after the inputs, with eA and eB the effective tags, a_shift_en is 1 and a_shift is eB-eA-1 when eB>eA, so that 00 means a right shift of 1, 01 of 2, 10 of 3 and 11 of 4. Otherwise a_shift_en is 0 and a_shift is 00.
- R3: One cycle after the inputs, prod_shift is eA-eB when eA>=eB and 0 otherwise.
- R4: Growth is present when the three bits of a_re_msb are not all equal, or the three bits of a_im_msb are not all equal. With t = max(eA,eB) + growth: when t is 4, acc_shift is 011 (right shift by one) and the tag is 11. Otherwise acc_shift is 100 (no shift) and the tag is t. acc_shift appears one cycle after the inputs.
- R5: The tag from R4 appears on tag_out five cycles after the inputs it belongs to.
- R6: An input cycle is valid when pass_n is high in that cycle or was high in the cycle before. When pass_n rises with start_n high, gwr becomes gwr + M - 1 modulo 32 from the next cycle. M is the largest tag on tag_out among valid words since the previous pass boundary, including one leaving in the rising cycle. At all other times gwr holds its value.
- R7: If no valid word left the pipeline since the last boundary, a rise of pass_n leaves gwr unchanged.
- R8: start_n low clears gwr to 0 from the next cycle, discards the pass maximum and begins a first pass. It has priority over a rise of pass_n.
- R9: In the cycle after a synchronous reset (rst_n low at a clock edge), gwr is 0, tag_out is 00, a_shift_en is 0, a_shift is 00, prod_shift is 0, acc_shift is 100, and a first pass is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_n | input | 1 | Start of FFT, active low for one cycle |
| pass_n | input | 1 | High during a pass, low on its last cycle and in the gap |
| tag_a | input | 2 | Weighting tag of the A word |
| tag_b | input | 2 | Weighting tag of the B word |
| a_re_msb | input | 3 | Top three bits of the real part of A |
| a_im_msb | input | 3 | Top three bits of the imaginary part of A |
| a_shift_en | output | 1 | A word must be shifted right |
| a_shift | output | 2 | A word right-shift code |
| prod_shift | output | 2 | Internal product right shift in places |
| acc_shift | output | 3 | Accumulator shift code |
| tag_out | output | 2 | Output word tag |
| gwr | output | 5 | Global weighting exponent, two's complement |

## Verification
The hardest case is the pass boundary, where the last valid word of a pass leaves the pipeline in the same cycle as pass_n rises, so it must still count toward the exponent update. The stimulus holds pass_n low for exactly five cycles to make them coincide, and uses longer gaps elsewhere. A start strobe issued late in a long gap produces a pass with no valid words (R7). A pass with all tags 00 and no growth drives the exponent from 0 down to -1, which wraps it.

// File: rtl/bfp_pkg.sv
// Shared widths and codes for the block floating point tag controller.
// Assumes 2-bit tags, 3 sign-check bits and a 5-bit exponent.
package bfp_pkg;
    parameter int TAG_W    = 2;
    parameter int TOP_W    = 3;
    parameter int GWR_W    = 5;
    parameter int PIPE_LAT = 5;
    localparam int TAG_MAX = (1 << TAG_W) - 1;
    typedef logic [TAG_W-1:0] tag_t;
    localparam logic [2:0] ACC_RIGHT1 = 3'b011;
    localparam logic [2:0] ACC_NONE   = 3'b100;
    localparam tag_t       TAG_SAME   = tag_t'(1);
endpackage

// File: rtl/bfp_grow.sv
// Growth detector: flags an A word whose top bits are not pure sign
// extension in either component. Purely combinational.
module bfp_grow
    import bfp_pkg::*;
(
    input  logic [TOP_W-1:0] re_top,
    input  logic [TOP_W-1:0] im_top,
    output logic             grow
);
    logic re_ok, im_ok;

    // A component is safe when all its top bits agree
    always_comb begin
        re_ok = (&re_top) | ~(|re_top);
        im_ok = (&im_top) | ~(|im_top);
        grow  = ~(re_ok & im_ok);
    end
endmodule

// File: rtl/bfp_align.sv
// Tag alignment: compares the effective tags and registers the A-word
// shift, product shift and accumulator shift. It also gives the
// saturated output tag combinationally. Assumes the tags are already
// forced to the neutral value during the first pass.
module bfp_align
    import bfp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tag_t       eff_a,
    input  tag_t       eff_b,
    input  logic       grow,
    output logic       a_shift_en,
    output logic [1:0] a_shift,
    output logic [1:0] prod_shift,
    output logic [2:0] acc_shift,
    output tag_t       tag_raw
);
    logic [TAG_W:0] sum;
    tag_t           big;
    logic           b_larger;
    tag_t           gap_b, gap_a;

    // Differences between tags and the combined weighting
    always_comb begin
        b_larger = eff_b > eff_a;
        gap_b    = eff_b - eff_a;
        gap_a    = eff_a - eff_b;
        big      = b_larger ? eff_b : eff_a;
        sum      = {1'b0, big} + {{TAG_W{1'b0}}, grow};
        tag_raw  = sum[TAG_W] ? tag_t'(TAG_MAX) : sum[TAG_W-1:0];
    end

    // Register the shift decisions for the cycle after the inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_shift_en <= 1'b0;
            a_shift    <= 2'b00;
            prod_shift <= 2'b00;
            acc_shift  <= ACC_NONE;
        end else begin
            a_shift_en <= b_larger;
            a_shift    <= b_larger ? 2'(gap_b - tag_t'(1)) : 2'b00;
            prod_shift <= b_larger ? 2'b00 : 2'(gap_a);
            acc_shift  <= sum[TAG_W] ? ACC_RIGHT1 : ACC_NONE;
        end
    end

    p_equal_tags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_a == eff_b) |=> (!a_shift_en && prod_shift == 2'b00));

    p_acc_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_shift == ACC_RIGHT1) || (acc_shift == ACC_NONE));

    p_shift_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        a_shift_en |-> (prod_shift == 2'b00));
endmodule

// File: rtl/bfp_gwr.sv
// Pass tracking: first-pass flag, input validity, pass-maximum tag and
// the global exponent. Assumes pass_n stays low long enough for the
// pipeline to drain before it rises.
module bfp_gwr
    import bfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_n,
    input  logic             pass_n,
    input  tag_t             out_tag,
    input  logic             out_valid,
    output logic             first_eff,
    output logic             in_valid,
    output logic [GWR_W-1:0] gwr
);
    logic pass_q, first_q, seen_q, rise, seen_now;
    tag_t max_q, max_now;

    // Boundary detection and running maximum including the leaving word
    always_comb begin
        rise      = pass_n & ~pass_q;
        first_eff = ~start_n | (first_q & ~rise);
        in_valid  = pass_n | pass_q;
        max_now   = (out_valid && out_tag > max_q) ? out_tag : max_q;
        seen_now  = seen_q | out_valid;
    end

    // Exponent update, pass maximum and first-pass state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q  <= 1'b1;
            first_q <= 1'b1;
            seen_q  <= 1'b0;
            max_q   <= '0;
            gwr     <= '0;
        end else begin
            pass_q <= pass_n;
            if (!start_n) begin
                gwr     <= '0;
                max_q   <= '0;
                seen_q  <= 1'b0;
                first_q <= 1'b1;
            end else if (rise) begin
                if (seen_now)
                    gwr <= gwr + GWR_W'(max_now) - GWR_W'(1);
                max_q   <= '0;
                seen_q  <= 1'b0;
                first_q <= 1'b0;
            end else if (out_valid) begin
                max_q  <= max_now;
                seen_q <= 1'b1;
            end
        end
    end

    p_gwr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_n && !rise) |=> $stable(gwr));

    p_gwr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_n && rise) |=> (GWR_W'(gwr - $past(gwr)) inside
                               {GWR_W'(0), GWR_W'(1), GWR_W'(2), {GWR_W{1'b1}}}));

    p_gwr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |=> (gwr == '0));
endmodule

// File: rtl/bfp_tag_ctrl.sv
// Top of the block floating point tag controller. Substitutes neutral
// tags in the first pass, aligns tags, and delays the output tag to
// match the butterfly latency. It feeds that tag back to the exponent
// logic.
module bfp_tag_ctrl
    import bfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_n,
    input  logic             pass_n,
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    input  logic [TOP_W-1:0] a_re_msb,
    input  logic [TOP_W-1:0] a_im_msb,
    output logic             a_shift_en,
    output logic [1:0]       a_shift,
    output logic [1:0]       prod_shift,
    output logic [2:0]       acc_shift,
    output logic [TAG_W-1:0] tag_out,
    output logic [GWR_W-1:0] gwr
);
    logic first_eff, in_valid, grow;
    tag_t eff_a, eff_b, tag_raw;
    tag_t tag_pipe [PIPE_LAT];
    logic val_pipe [PIPE_LAT];

    // Neutral tags while the first pass runs
    always_comb begin
        eff_a = first_eff ? TAG_SAME : tag_a;
        eff_b = first_eff ? TAG_SAME : tag_b;
    end

    bfp_grow u_grow (
        .re_top (a_re_msb),
        .im_top (a_im_msb),
        .grow   (grow)
    );

    bfp_align u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .eff_a      (eff_a),
        .eff_b      (eff_b),
        .grow       (grow),
        .a_shift_en (a_shift_en),
        .a_shift    (a_shift),
        .prod_shift (prod_shift),
        .acc_shift  (acc_shift),
        .tag_raw    (tag_raw)
    );

    // Delay line carrying the tag and its validity to the output
    for (genvar s = 0; s < PIPE_LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_pipe[s] <= '0;
                val_pipe[s] <= 1'b0;
            end else if (s == 0) begin
                tag_pipe[s] <= tag_raw;
                val_pipe[s] <= in_valid;
            end else begin
                tag_pipe[s] <= tag_pipe[(s == 0) ? 0 : s-1];
                val_pipe[s] <= val_pipe[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign tag_out = tag_pipe[PIPE_LAT-1];

    bfp_gwr u_gwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n   (start_n),
        .pass_n    (pass_n),
        .out_tag   (tag_out),
        .out_valid (val_pipe[PIPE_LAT-1]),
        .first_eff (first_eff),
        .in_valid  (in_valid),
        .gwr       (gwr)
    );

    p_sat_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_shift == ACC_RIGHT1) |-> ##4 (tag_out == tag_t'(TAG_MAX)));
endmodule

// File: tb/tb_bfp_tag_ctrl.sv
module tb_bfp_tag_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0, start_n = 1'b1, pass_n = 1'b0;
    logic [1:0] tag_a = 0, tag_b = 0;
    logic [2:0] a_re_msb = 0, a_im_msb = 0;
    logic a_shift_en;
    logic [1:0] a_shift, prod_shift, tag_out;
    logic [2:0] acc_shift;
    logic [4:0] gwr;

    int checks = 0, fails = 0, cycles = 0;
    int lcg = 12345;
    // reference model state
    int m_en = 0, m_ash = 0, m_psh = 0, m_acc = 4, m_gwr = 0;
    int m_max = 0, m_seen = 0, m_first = 1, m_pq = 1;
    int tq[5], vq[5];

    always #4 clk = ~clk;

    bfp_tag_ctrl dut (.clk(clk), .rst_n(rst_n), .start_n(start_n), .pass_n(pass_n),
        .tag_a(tag_a), .tag_b(tag_b), .a_re_msb(a_re_msb), .a_im_msb(a_im_msb),
        .a_shift_en(a_shift_en), .a_shift(a_shift), .prod_shift(prod_shift),
        .acc_shift(acc_shift), .tag_out(tag_out), .gwr(gwr));

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int rnd(input int n);
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return (lcg >>> 8) % n;
    endfunction

    function automatic int all_eq(input int v);
        return (v == 0 || v == 7) ? 1 : 0;
    endfunction

    // Apply one cycle of inputs, advance the model, compare at mid-cycle
    task automatic tick(input int rst, input int st, input int ps, input int ta,
                        input int tb, input int ar, input int ai);
        int rise, first, ea, eb, g, t, big, vin, outt, outv, mnow;
        rst_n = (rst == 0); start_n = st[0]; pass_n = ps[0];
        tag_a = ta[1:0]; tag_b = tb[1:0]; a_re_msb = ar[2:0]; a_im_msb = ai[2:0];
        rise  = (ps == 1 && m_pq == 0);
        first = (st == 0) || (m_first == 1 && !rise);
        ea = first ? 1 : ta;
        eb = first ? 1 : tb;
        g = (all_eq(ar) && all_eq(ai)) ? 0 : 1;
        big = (ea > eb) ? ea : eb;
        t = big + g;
        vin = (ps == 1 || m_pq == 1);
        outt = tq[4]; outv = vq[4];
        @(posedge clk);
        if (rst) begin
            m_en = 0; m_ash = 0; m_psh = 0; m_acc = 4; m_gwr = 0;
            m_max = 0; m_seen = 0; m_first = 1; m_pq = 1;
            for (int k = 0; k < 5; k++) begin tq[k] = 0; vq[k] = 0; end
        end else begin
            m_en  = (eb > ea);
            m_ash = (eb > ea) ? eb - ea - 1 : 0;
            m_psh = (ea >= eb) ? ea - eb : 0;
            m_acc = (t == 4) ? 3 : 4;
            mnow = (outv && outt > m_max) ? outt : m_max;
            if (st == 0) begin
                m_gwr = 0; m_max = 0; m_seen = 0; m_first = 1;
            end else if (rise) begin
                if (m_seen || outv) m_gwr = (m_gwr + mnow - 1) & 31;
                m_max = 0; m_seen = 0; m_first = 0;
            end else if (outv) begin
                m_max = mnow; m_seen = 1;
            end
            m_pq = ps;
            for (int k = 4; k > 0; k--) begin tq[k] = tq[k-1]; vq[k] = vq[k-1]; end
            tq[0] = (t == 4) ? 3 : t;
            vq[0] = vin;
        end
        @(negedge clk);
        chk("R2", "a_shift_en", a_shift_en, m_en);
        chk("R2", "a_shift", a_shift, m_ash);
        chk("R3", "prod_shift", prod_shift, m_psh);
        chk("R4", "acc_shift", acc_shift, m_acc);
        chk("R5", "tag_out", tag_out, tq[4]);
        chk("R6", "gwr", gwr, m_gwr);
    endtask

    // mode 0 random, 1 all tags 00 no growth, 2 tags 11 with growth
    task automatic run_pass(input int n, input int mode, input int gap, input int start);
        for (int i = 0; i < n; i++) begin
            int ta, tb, ar, ai, last;
            last = (i == n - 1);
            if (mode == 0) begin ta = rnd(4); tb = rnd(4); ar = rnd(8); ai = rnd(8); end
            else if (mode == 1) begin ta = 0; tb = 0; ar = 7; ai = 0; end
            else begin ta = 3; tb = 3; ar = 3; ai = 0; end
            tick(0, (start && i == 0) ? 0 : 1, last ? 0 : 1, ta, tb, ar, ai);
        end
        for (int i = 0; i < gap; i++) tick(0, 1, 0, rnd(4), rnd(4), rnd(8), rnd(8));
    endtask

    initial begin
        for (int k = 0; k < 5; k++) begin tq[k] = 0; vq[k] = 0; end
        @(negedge clk);
        tick(1, 1, 0, 0, 0, 0, 0);
        tick(1, 1, 0, 0, 0, 0, 0);
        // R9: reset state
        chk("R9", "gwr after reset", gwr, 0);
        chk("R9", "acc_shift after reset", acc_shift, 4);
        chk("R9", "tag_out after reset", tag_out, 0);
        // R1: first pass tags ignored; tag_b=3, tag_a=0 would otherwise shift A
        tick(0, 0, 1, 0, 3, 0, 0);
        tick(0, 1, 1, 0, 3, 0, 0);
        chk("R1", "a_shift_en in first pass", a_shift_en, 0);
        chk("R1", "prod_shift in first pass", prod_shift, 0);
        run_pass(30, 0, 4, 0);       // first pass, minimal 5-cycle low window
        run_pass(40, 0, 4, 0);       // second pass with real tags
        run_pass(40, 2, 8, 0);       // saturating growth, gwr +2
        run_pass(25, 0, 12, 0);
        // R8: start in a long gap clears the exponent
        tick(0, 0, 0, 1, 1, 0, 0);
        chk("R8", "gwr after start", gwr, 0);
        for (int i = 0; i < 8; i++) tick(0, 1, 0, 2, 1, 0, 0);
        // R7: rise with no valid word since start leaves gwr at 0
        tick(0, 1, 1, 0, 0, 0, 0);
        tick(0, 1, 1, 0, 0, 0, 0);
        chk("R7", "gwr after empty pass", gwr, 0);
        run_pass(20, 1, 6, 0);       // all 00: gwr wraps to 31
        tick(0, 1, 1, 0, 0, 0, 0);
        tick(0, 1, 1, 0, 0, 0, 0);
        chk("R6", "gwr decrement wrap", gwr, 31);
        run_pass(30, 0, 5, 1);       // new FFT started on first data cycle
        run_pass(50, 0, 4, 0);
        run_pass(50, 0, 4, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog expired got %0d expected 0", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule